// File: doc/BRIEF.md
# Bit-Oriented Synchronous Frame Transmitter

This block turns bytes written by a processor into bit-oriented synchronous frames on one serial line. Bytes go into a small first-in first-out buffer. The serializer drains that buffer one bit at a time. It advances only on clocks where the transmit bit enable is high. This enable is a single-cycle pulse, derived elsewhere from the line rate. Each frame is built as follows:

- An opening flag is sent first, with no command needed.
- The data bits follow. A zero is inserted after any run of five ones.
- A 16-bit check sequence comes next.
- A closing flag ends the frame.

The serial line can be sent plain or with transition coding. The request-to-send output is driven low for the whole frame. It rises only after the last bit of the closing flag has been on the line for its full bit time.

The processor marks the final byte of a message with an end flag. If the buffer runs dry in mid-frame before that mark, the block aborts the frame with a run of ones. A single status latch tells software that the end of the current frame is under way, either the check sequence or an abort. This latch clears by itself when the next frame starts.

Top module: `sdlc_tx_framer`

## Requirements
- R1: After reset, `txd` is 1, `rts_n` is 1, `eom_status` is 0 and `fifo_full` is 0.
- R2: The buffer holds FIFO_DEPTH (default 4) bytes. `fifo_full` is 1 once that many bytes are stored and not yet taken. A write while `fifo_full` is 1 is dropped, so that byte is never sent.
- R3: A frame starts at the first `bit_en` found in idle with the buffer non-empty. On that edge `rts_n` goes to 0 and the line carries an idle 1 bit. The next eight bits are the flag 0x7E, least significant bit first (0,1,1,1,1,1,1,0).
- R4: In data and check-sequence bits, a 0 is inserted after every five consecutive 1 bits. This still applies right before the closing flag or an abort. Flags and abort bits are never stuffed.
- R5: Data bytes go out least significant bit first. After the byte written with `wr_eom` = 1, the block sends 16 check bits. These are the complement of a CRC computed with the reflected polynomial 0x8408, preset to 0xFFFF and covering the data bits. They are sent least significant bit first.
- R6: The closing flag 0x7E follows the check bits. At the next `bit_en` after its last bit, `rts_n` returns to 1 and `txd` is 1, provided the buffer is empty.
- R7: With `nrzi_en` = 1, a 0 bit toggles `txd` and a 1 bit holds it. While idle, `txd` is forced to 1 in both codings.
- R8: If the buffer is empty at a byte boundary and the last byte sent lacked the end mark, the block sends eight 1 bits (an abort) and then goes idle. `rts_n` rises at the following `bit_en`.
- R9: `eom_status` becomes 1 when the check bits or an abort begin. It returns to 0 on the edge that starts the next frame.
- R10: `txd` changes only on clocks where `bit_en` is 1. `bit_en` pulses are at least MIN_BIT_GAP (default 4) clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle pulse that advances the serial line by one bit |
| nrzi_en | input | 1 | 1 selects transition coding of the line |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_byte | input | 8 | Byte to store |
| wr_eom | input | 1 | Marks the written byte as the last of its message |
| fifo_full | output | 1 | Buffer holds FIFO_DEPTH bytes |
| txd | output | 1 | Serial data line |
| rts_n | output | 1 | Request to send, active low, low for the frame |
| eom_status | output | 1 | End of frame in progress (check bits or abort) |

## Verification
The bench builds the block with FIFO_DEPTH = 4 and MIN_BIT_GAP = 4. The bit enable is pulsed exactly every fourth clock, so every bit moves at the highest rate allowed. With four entries, a single frame fills the buffer. That makes the dropped fifth write observable in the sent stream. Frames of 0xFF runs exercise stuffing inside data and check bits and stuffing right before the closing flag. They are sent in both line codings and compared against an expected bit stream that the bench builds itself.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPEN, ST_DATA, ST_FCS, ST_CLOSE, ST_ABORT
  } tx_state_e;

  localparam logic [7:0]  FLAG_PAT  = 8'h7E;
  localparam logic [15:0] CRC_POLY  = 16'h8408;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;

  // one bit of the reflected CRC-16 recurrence
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    crc_step = {1'b0, c[15:1]} ^ (((c[0] ^ b) == 1'b1) ? CRC_POLY : 16'h0000);
  endfunction
endpackage

// File: rtl/sdlc_tx_fifo.sv
module sdlc_tx_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wr_ptr, rd_ptr;
  logic wr_ok;

  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign wr_ok = wr_en && !full;
  assign rd_data = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en && !empty) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr - rd_ptr) <= (AW+1)'(DEPTH));
  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
endmodule

// File: rtl/sdlc_tx_serializer.sv
module sdlc_tx_serializer
  import sdlc_tx_pkg::*;
#(
  parameter int MIN_GAP = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       nrzi_en,
  input  logic       fifo_empty,
  input  logic [8:0] fifo_word,
  output logic       fifo_pop,
  output logic       txd,
  output logic       rts_n,
  output logic       eom_status
);
  localparam int GW = $clog2(MIN_GAP + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(MIN_GAP - 1);

  tx_state_e   state;
  logic [15:0] shreg;
  logic [4:0]  cnt;
  logic [2:0]  ones;
  logic [15:0] crc;
  logic        eom_q;

  logic        stuff, cur_bit, unit_end, take_next;
  logic [15:0] crc_nx;

  assign stuff     = (ones == 3'd5);
  assign cur_bit   = stuff ? 1'b0 : shreg[0];
  assign crc_nx    = crc_step(crc, shreg[0]);
  assign unit_end  = (state != ST_IDLE) && !stuff && (cnt == 5'd1);
  assign take_next = unit_end && !fifo_empty &&
                     ((state == ST_OPEN) || (state == ST_DATA && !eom_q));
  assign fifo_pop  = bit_en && take_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; shreg <= '0; cnt <= '0; ones <= '0;
      crc <= CRC_PRESET; eom_q <= 1'b0;
      txd <= 1'b1; rts_n <= 1'b1; eom_status <= 1'b0;
    end else if (bit_en) begin
      if (state == ST_IDLE) txd <= 1'b1;
      else if (nrzi_en)     txd <= cur_bit ? txd : ~txd;
      else                  txd <= cur_bit;

      if (state == ST_IDLE) begin
        ones <= '0;
        if (!fifo_empty) begin
          state <= ST_OPEN; shreg <= {8'h00, FLAG_PAT}; cnt <= 5'd8;
          rts_n <= 1'b0; eom_status <= 1'b0; crc <= CRC_PRESET; eom_q <= 1'b0;
        end else begin
          rts_n <= 1'b1;
        end
      end else if (stuff) begin
        ones <= '0;
      end else begin
        shreg <= {1'b0, shreg[15:1]};
        cnt   <= cnt - 5'd1;
        if (state == ST_DATA) crc <= crc_nx;
        ones <= ((state == ST_DATA || state == ST_FCS) && shreg[0]) ? ones + 3'd1 : 3'd0;
        if (unit_end) begin
          unique case (state)
            ST_OPEN, ST_DATA: begin
              if (state == ST_DATA && eom_q) begin
                state <= ST_FCS; shreg <= ~crc_nx; cnt <= 5'd16; eom_status <= 1'b1;
              end else if (take_next) begin
                state <= ST_DATA; shreg <= {8'h00, fifo_word[7:0]};
                eom_q <= fifo_word[8]; cnt <= 5'd8;
              end else begin
                state <= ST_ABORT; shreg <= 16'h00FF; cnt <= 5'd8; eom_status <= 1'b1;
              end
            end
            ST_FCS: begin
              state <= ST_CLOSE; shreg <= {8'h00, FLAG_PAT}; cnt <= 5'd8;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // bit-rate watch for the checks below
  logic [GW-1:0] gap;
  always_ff @(posedge clk) begin
    if (rst)            gap <= GAP_MAX;
    else if (bit_en)    gap <= '0;
    else if (gap != GAP_MAX) gap <= gap + 1'b1;
  end

  // R4
  ones_limit_chk: assert property (@(posedge clk) disable iff (rst) ones <= 3'd5);
  // R10
  txd_hold_chk: assert property (@(posedge clk) disable iff (rst) !bit_en |=> $stable(txd));
  // R10
  bit_rate_chk: assert property (@(posedge clk) disable iff (rst) bit_en |-> gap == GAP_MAX);
  // R6
  rts_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(rts_n) |-> txd);
  // R3
  rts_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rts_n) |-> (txd && !eom_status));
  // R9
  status_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(eom_status) |-> !rts_n);
endmodule

// File: rtl/sdlc_tx_framer.sv
module sdlc_tx_framer #(
  parameter int FIFO_DEPTH  = 4,
  parameter int MIN_BIT_GAP = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       nrzi_en,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  input  logic       wr_eom,
  output logic       fifo_full,
  output logic       txd,
  output logic       rts_n,
  output logic       eom_status
);
  localparam int ENTRY_W = 9;

  logic [ENTRY_W-1:0] head;
  logic fifo_empty, pop;

  sdlc_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_data({wr_eom, wr_byte}),
    .rd_en(pop), .rd_data(head),
    .empty(fifo_empty), .full(fifo_full)
  );

  sdlc_tx_serializer #(.MIN_GAP(MIN_BIT_GAP)) u_ser (
    .clk(clk), .rst(rst), .bit_en(bit_en), .nrzi_en(nrzi_en),
    .fifo_empty(fifo_empty), .fifo_word(head), .fifo_pop(pop),
    .txd(txd), .rts_n(rts_n), .eom_status(eom_status)
  );
endmodule

// File: tb/tb_sdlc_tx_framer.sv
module tb_sdlc_tx_framer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, bit_en, nrzi_en, wr_en, wr_eom;
  logic [7:0] wr_byte;
  logic fifo_full, txd, rts_n, eom_status;

  sdlc_tx_framer dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .nrzi_en(nrzi_en),
    .wr_en(wr_en), .wr_byte(wr_byte), .wr_eom(wr_eom),
    .fifo_full(fifo_full), .txd(txd), .rts_n(rts_n), .eom_status(eom_status)
  );

  int n_checks = 0, n_fail = 0, hold_err = 0, st_ones = 0, exp_n = 0;
  bit exp_bits [256];
  logic line_prev = 1'b1;

  localparam int NF = 4;
  localparam logic [31:0] F_DATA [NF] = '{32'h00332211, 32'hF81F7EFF, 32'h000000A5, 32'h0000FFFF};
  localparam int          F_LEN  [NF] = '{3, 4, 1, 3};
  localparam bit          F_NRZI [NF] = '{1'b0, 1'b0, 1'b1, 1'b1};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input bit b);
    exp_bits[exp_n] = b; exp_n++;
  endtask

  task automatic push_stuffed(input bit b);
    push(b);
    st_ones = b ? st_ones + 1 : 0;
    if (st_ones == 5) begin push(1'b0); st_ones = 0; end
  endtask

  task automatic push_flag();
    for (int k = 0; k < 8; k++) push(k != 0 && k != 7);
  endtask

  // expected line bits from the frame-start bit to the last flag/abort bit
  task automatic build_exp(input logic [31:0] d, input int len, input bit abort);
    logic [15:0] crc = 16'hFFFF;
    exp_n = 0; st_ones = 0;
    push(1'b1);
    push_flag();
    for (int i = 0; i < len; i++)
      for (int k = 0; k < 8; k++) begin
        crc = (crc >> 1) ^ (((crc[0] ^ d[8*i+k]) == 1'b1) ? 16'h8408 : 16'h0000);
        push_stuffed(d[8*i+k]);
      end
    if (abort) begin
      for (int k = 0; k < 8; k++) push(1'b1);
    end else begin
      crc = ~crc;
      for (int k = 0; k < 16; k++) push_stuffed(crc[k]);
      push_flag();
    end
  endtask

  task automatic wr(input logic [7:0] b, input logic eom);
    @(negedge clk); wr_en = 1'b1; wr_byte = b; wr_eom = eom;
    @(negedge clk); wr_en = 1'b0; wr_eom = 1'b0;
  endtask

  task automatic step(output bit b, output logic r, output logic s);
    logic t0;
    @(negedge clk); bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
    b = nrzi_en ? (txd == line_prev) : txd;
    line_prev = txd; r = rts_n; s = eom_status; t0 = txd;
    @(negedge clk);
    @(negedge clk);
    if (txd !== t0) hold_err++;
  endtask

  task automatic collect(input string tag);
    bit b; logic r, s;
    int bit_err = 0, rts_err = 0;
    for (int i = 0; i < exp_n; i++) begin
      step(b, r, s);
      if (b != exp_bits[i]) bit_err++;
      if (r !== 1'b0) rts_err++;
      if (i == 0) chk(s === 1'b0, {"R9 clear at start ", tag}, s, 0);
    end
    chk(bit_err == 0, {"R3 R4 R5 R6 R7 bit stream ", tag}, bit_err, 0);
    chk(rts_err == 0, {"R3 rts_n low in frame ", tag}, rts_err, 0);
    step(b, r, s);
    chk(r === 1'b1 && txd === 1'b1, {"R6 R7 idle after frame ", tag}, {r, txd}, 3);
    chk(s === 1'b1, {"R9 status set ", tag}, s, 1);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    bit b; logic r, s;
    rst = 1'b1; bit_en = 1'b0; nrzi_en = 1'b0; wr_en = 1'b0; wr_byte = '0; wr_eom = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(txd === 1'b1, "R1 txd", txd, 1);
    chk(rts_n === 1'b1, "R1 rts_n", rts_n, 1);
    chk(eom_status === 1'b0, "R1 eom_status", eom_status, 0);
    chk(fifo_full === 1'b0, "R1 fifo_full", fifo_full, 0);
    step(b, r, s);
    chk(r === 1'b1 && txd === 1'b1, "R3 no frame when empty", {r, txd}, 3);

    // table of frames
    for (int f = 0; f < NF; f++) begin
      @(negedge clk); nrzi_en = F_NRZI[f];
      build_exp(F_DATA[f], F_LEN[f], 1'b0);
      for (int i = 0; i < F_LEN[f]; i++)
        wr(F_DATA[f][8*i +: 8], i == F_LEN[f] - 1);
      collect($sformatf("frame %0d", f));
    end

    // R2 fill, dropped write
    @(negedge clk); nrzi_en = 1'b0;
    wr(8'hA1, 1'b0); wr(8'hB2, 1'b0); wr(8'hC3, 1'b0); wr(8'hD4, 1'b1);
    chk(fifo_full === 1'b1, "R2 full after four", fifo_full, 1);
    wr(8'hE5, 1'b1);
    build_exp(32'hD4C3B2A1, 4, 1'b0);
    collect("R2 full frame");
    chk(fifo_full === 1'b0, "R2 drained", fifo_full, 0);
    step(b, r, s);
    chk(r === 1'b1, "R2 dropped byte not sent", r, 1);

    // R8 underrun abort, line coded
    @(negedge clk); nrzi_en = 1'b1;
    wr(8'h11, 1'b0); wr(8'h22, 1'b0);
    build_exp(32'h00002211, 2, 1'b1);
    collect("R8 abort");

    chk(hold_err == 0, "R10 txd held between bit_en", hold_err, 0);
    report();
  end
endmodule